// File: doc/BRIEF.md
# Sign-Sign Tap Adaptation Engine for a Decision-Feedback Equalizer

This block computes the tap weights of a decision-feedback equalizer with four feedback taps and one DC-offset tap. On every symbol clock it receives one bit for the sign of the equalizer error and one bit for the current binary decision. It keeps the most recent decisions in a short shift chain. For each tap it forms an up or down vote by comparing the error sign with that tap's regressor. The regressor of feedback tap k is the decision made k symbols earlier. The regressor of the offset tap is always +1.

By default, a small up/down pre-counter in front of each tap absorbs the votes. The tap's coefficient counter moves by one code only when this pre-counter overflows or underflows. As a result, a run of isolated noisy votes is averaged before the weight changes. A build-time option removes the pre-counters and lets every vote step a wider coefficient counter directly. The coefficient words are driven out side by side, one word per tap, as codes for the weighting DACs.

Adaptation is gated by an enable input. The decision chain keeps shifting whether or not adaptation is enabled.

Top module: `sslms_adapt`

## Requirements
- R1: While `rst_n` is low at a rising edge, every coefficient is set to mid-code, every pre-counter is set to 8, and every stored decision is set to +1. Mid-code is 32 for the 6-bit word and 512 for the 10-bit word.
- R2: Feedback tap k (k = 1..4) uses the decision that was presented k rising edges before the current vote.
- R3: Bit value 1 encodes +1 and bit value 0 encodes −1, for both the decisions and the error sign. A tap votes up when the error-sign bit equals its regressor bit and votes down otherwise. The offset tap's regressor is the constant 1.
- R4: With the pre-counters in place, an up vote increments a tap's 4-bit pre-counter and a down vote decrements it. The coefficient does not change until an overflow or an underflow occurs.
- R5: An up vote that arrives while the pre-counter holds 15 raises the coefficient by one at that same edge and returns the pre-counter to 8. Starting from reset, the 8th consecutive up vote is the first one that moves the coefficient.
- R6: A down vote that arrives while the pre-counter holds 0 lowers the coefficient by one at that same edge and returns the pre-counter to 8. Starting from reset, the 9th consecutive down vote is the first one that moves the coefficient.
- R7: A coefficient saturates. It stays at its all-ones code when a further step up is requested, and stays at 0 when a further step down is requested.
- R8: While `adapt_en` is low, no pre-counter and no coefficient changes, but the decision chain keeps shifting.
- R9: With `BYPASS_PRE` set to 1, each vote steps a 10-bit coefficient by one directly, with the same saturation as in R7.
- R10: The word for tap t sits at bits [t*W +: W] of `coef_o`. Tap 0 is the offset tap and taps 1..4 are the feedback taps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Synchronous reset, active low |
| adapt_en | input | 1 | High to let the votes update the counters |
| err_sgn_i | input | 1 | Sign of the equalizer error (1 = +1, 0 = −1) |
| dec_i | input | 1 | Current slicer decision (1 = +1, 0 = −1) |
| coef_o | output | (N_FB+1)*W | Packed coefficient codes; W is 6, or 10 when the pre-counters are bypassed |

## Verification
The inputs that form a vote are seen at one rising edge. A pre-counter step, and a coefficient step caused by carry or borrow, both take effect at that same edge, so every coefficient result is due one edge after its stimulus. A new decision reaches feedback tap k's regressor k edges after it is presented. The bench drives its inputs on falling edges and advances a reference model at each rising edge. It then compares every tap word at the next falling edge, so each comparison falls exactly one edge after the stimulus that caused it. Long runs of all-up and all-down votes reach both saturation limits of the default build and of a bypass build. Random decisions and error signs exercise the tap delays, and an interval with adaptation disabled is checked while decisions keep changing.

// File: rtl/sslms_pkg.sv
// Shared helpers for the sign-sign adaptation engine.
// Assumes every width passed in is at least 2.
package sslms_pkg;

    // Purpose: produce the mid-scale code (MSB set, other bits clear) for a W-bit counter
    function automatic logic [31:0] mid_code(input int unsigned w);
        return 32'(1) << (w - 1);
    endfunction

    // Purpose: produce the all-ones code for a W-bit counter
    function automatic logic [31:0] top_code(input int unsigned w);
        return (32'(1) << w) - 32'(1);
    endfunction

endpackage

// File: rtl/sslms_dec_line.sv
// Decision history chain.
// Bit i of hist_o holds the decision presented i+1 edges earlier.
// On reset every stage holds +1. The chain shifts on every edge, regardless of any enable.
// Assumes DEPTH >= 2.
module sslms_dec_line #(
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             din,
    output logic [DEPTH-1:0] hist_o
);

    // Purpose: shift the newest decision in at the low end
    always_ff @(posedge clk) begin
        if (!rst_n) hist_o <= '1;
        else        hist_o <= {hist_o[DEPTH-2:0], din};
    end

    // R2
    newest_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> hist_o[0] == $past(din));

    // R2
    chain_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> hist_o[DEPTH-1:1] == $past(hist_o[DEPTH-2:0]));

endmodule

// File: rtl/sslms_precount.sv
// Vote-averaging pre-counter.
// Resets to mid-scale. An up vote at the top code raises carry_o, and a down vote at zero
// raises borrow_o, combinationally in the cycle of that vote. Either event reloads mid-scale.
// Assumes up and dn are never both high.
module sslms_precount #(
    parameter int W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic up,
    input  logic dn,
    output logic carry_o,
    output logic borrow_o
);
    import sslms_pkg::*;

    localparam logic [W-1:0] MID = W'(mid_code(W));
    localparam logic [W-1:0] TOP = W'(top_code(W));

    logic [W-1:0] cnt;

    // Purpose: flag overflow and underflow for the vote in this cycle
    always_comb begin
        carry_o  = en && up && (cnt == TOP);
        borrow_o = en && dn && (cnt == '0);
    end

    // Purpose: count enabled votes, reloading mid-scale on overflow or underflow
    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt <= MID;
        else if (carry_o || borrow_o) cnt <= MID;
        else if (en && up)           cnt <= cnt + 1'b1;
        else if (en && dn)           cnt <= cnt - 1'b1;
    end

    // R5
    carry_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        carry_o |=> cnt == MID);

    // R6
    borrow_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        borrow_o |=> cnt == MID);

    // R4
    pre_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && up && cnt != TOP) |=> cnt == $past(cnt) + 1'b1);

    // R8
    pre_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(cnt));

endmodule

// File: rtl/sslms_coef.sv
// Saturating up/down coefficient counter.
// Resets to mid-code, which represents zero weight. An enabled inc raises the count by one
// and an enabled dec lowers it by one. The count clips at all-ones and at zero.
// Assumes inc and dec are never both high.
module sslms_coef #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         inc,
    input  logic         dec,
    output logic [W-1:0] coef_o
);
    import sslms_pkg::*;

    localparam logic [W-1:0] MID = W'(mid_code(W));
    localparam logic [W-1:0] TOP = W'(top_code(W));

    logic step_up, step_dn;

    // Purpose: qualify the step requests with the enable and the clipping limits
    always_comb begin
        step_up = en && inc && (coef_o != TOP);
        step_dn = en && dec && (coef_o != '0);
    end

    // Purpose: hold the tap weight
    always_ff @(posedge clk) begin
        if (!rst_n)       coef_o <= MID;
        else if (step_up) coef_o <= coef_o + 1'b1;
        else if (step_dn) coef_o <= coef_o - 1'b1;
    end

    // R7
    sat_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (coef_o == TOP && inc) |=> coef_o == TOP);

    // R7
    sat_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (coef_o == '0 && dec) |=> coef_o == '0);

    // R8
    coef_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(coef_o));

endmodule

// File: rtl/sslms_adapt.sv
// Sign-sign LMS tap adaptation engine.
// Holds one offset tap (tap 0, regressor +1) and N_FB feedback taps (tap k uses the decision
// from k symbols earlier). Each tap votes up when the error sign equals its regressor bit.
// With BYPASS_PRE = 0, votes pass through a PRE_W-bit pre-counter whose carry or borrow steps
// a COEF_W-bit coefficient. With BYPASS_PRE = 1, votes step a WIDE_W-bit coefficient directly.
// Assumes N_FB >= 2.
module sslms_adapt #(
    parameter int N_FB       = 4,
    parameter int PRE_W      = 4,
    parameter int COEF_W     = 6,
    parameter int WIDE_W     = 10,
    parameter bit BYPASS_PRE = 1'b0,
    localparam int NT        = N_FB + 1,
    localparam int CW        = BYPASS_PRE ? WIDE_W : COEF_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           adapt_en,
    input  logic           err_sgn_i,
    input  logic           dec_i,
    output logic [NT*CW-1:0] coef_o
);
    import sslms_pkg::*;

    localparam logic [CW-1:0]    MIDC    = CW'(mid_code(CW));
    localparam logic [NT*CW-1:0] ALL_MID = {NT{MIDC}};

    logic [N_FB-1:0] hist;
    logic [NT-1:0]   regr;
    logic [NT-1:0]   vote_up;
    logic [NT-1:0]   vote_dn;

    sslms_dec_line #(.DEPTH(N_FB)) u_line (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (dec_i),
        .hist_o (hist)
    );

    // Purpose: build each tap's regressor and its up/down vote
    always_comb begin
        regr    = {hist, 1'b1};
        vote_up = ~({NT{err_sgn_i}} ^ regr);
        vote_dn =   {NT{err_sgn_i}} ^ regr;
    end

    for (genvar t = 0; t < NT; t++) begin : g_tap
        logic [CW-1:0] word;
        if (BYPASS_PRE) begin : g_direct
            sslms_coef #(.W(CW)) u_coef (
                .clk    (clk),
                .rst_n  (rst_n),
                .en     (adapt_en),
                .inc    (vote_up[t]),
                .dec    (vote_dn[t]),
                .coef_o (word)
            );
        end else begin : g_filtered
            logic carry, borrow;
            sslms_precount #(.W(PRE_W)) u_pre (
                .clk      (clk),
                .rst_n    (rst_n),
                .en       (adapt_en),
                .up       (vote_up[t]),
                .dn       (vote_dn[t]),
                .carry_o  (carry),
                .borrow_o (borrow)
            );
            sslms_coef #(.W(CW)) u_coef (
                .clk    (clk),
                .rst_n  (rst_n),
                .en     (adapt_en),
                .inc    (carry),
                .dec    (borrow),
                .coef_o (word)
            );
        end
        assign coef_o[t*CW +: CW] = word;
    end

    // R1
    reset_mid_chk: assert property (@(posedge clk)
        !rst_n |=> coef_o == ALL_MID);

    // R8
    top_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adapt_en |=> $stable(coef_o));

endmodule

// File: tb/sslms_adapt_tb.sv
`timescale 1ns/1ps
module sslms_adapt_tb;

    localparam int NT = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic adapt_en = 1'b0;
    logic err_sgn_i = 1'b1;
    logic dec_i = 1'b1;
    logic [NT*6-1:0]  coef_a;
    logic [NT*10-1:0] coef_b;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // reference model state
    int m_pre [NT];
    int m_cf  [NT];
    int m_wd  [NT];
    int m_h   [1:4];

    always #2.5 clk = ~clk;

    sslms_adapt u_dut (
        .clk(clk), .rst_n(rst_n), .adapt_en(adapt_en),
        .err_sgn_i(err_sgn_i), .dec_i(dec_i), .coef_o(coef_a)
    );

    sslms_adapt #(.BYPASS_PRE(1'b1)) u_dut_byp (
        .clk(clk), .rst_n(rst_n), .adapt_en(adapt_en),
        .err_sgn_i(err_sgn_i), .dec_i(dec_i), .coef_o(coef_b)
    );

    // Advance the reference model by one rising edge, using the inputs present at that edge
    task automatic model_step();
        int r;
        bit up;
        if (!rst_n) begin
            for (int t = 0; t < NT; t++) begin
                m_pre[t] = 8; m_cf[t] = 32; m_wd[t] = 512;
            end
            for (int k = 1; k <= 4; k++) m_h[k] = 1;
        end else begin
            for (int t = 0; t < NT; t++) begin
                r  = (t == 0) ? 1 : m_h[t];
                up = (int'(err_sgn_i) == r);
                if (adapt_en) begin
                    if (up) begin
                        if (m_pre[t] == 15) begin
                            m_pre[t] = 8;
                            if (m_cf[t] < 63) m_cf[t]++;
                        end else m_pre[t]++;
                        if (m_wd[t] < 1023) m_wd[t]++;
                    end else begin
                        if (m_pre[t] == 0) begin
                            m_pre[t] = 8;
                            if (m_cf[t] > 0) m_cf[t]--;
                        end else m_pre[t]--;
                        if (m_wd[t] > 0) m_wd[t]--;
                    end
                end
            end
            for (int k = 4; k >= 2; k--) m_h[k] = m_h[k-1];
            m_h[1] = int'(dec_i);
        end
    endtask

    // One symbol: edge, model update, then compare at the falling edge (R10 packing via slices)
    task automatic tick(input string req);
        @(posedge clk);
        model_step();
        @(negedge clk);
        for (int t = 0; t < NT; t++) begin
            total++;
            if (int'(coef_a[t*6 +: 6]) != m_cf[t]) begin
                bad++;
                $display("FAIL %s tap%0d filtered: actual=%0d expected=%0d",
                         req, t, coef_a[t*6 +: 6], m_cf[t]);
            end
            total++;
            if (int'(coef_b[t*10 +: 10]) != m_wd[t]) begin
                bad++;
                $display("FAIL %s tap%0d bypass: actual=%0d expected=%0d",
                         req, t, coef_b[t*10 +: 10], m_wd[t]);
            end
        end
    endtask

    // Watchdog: an expired run counts as one failed check
    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        rst_n = 1'b0;
        tick("R1");
        tick("R1");
        @(negedge clk);
        rst_n = 1'b1;
        adapt_en = 1'b1;

        // R3/R4/R5/R9/R7: all votes up (err=+1, decisions +1) until both builds saturate high
        err_sgn_i = 1'b1; dec_i = 1'b1;
        for (int i = 0; i < 560; i++) tick("R3 R4 R5 R7 R9");

        // R3/R6/R7/R9: all votes down (err=-1, decisions +1) until both builds reach zero
        err_sgn_i = 1'b0;
        for (int i = 0; i < 1080; i++) tick("R3 R6 R7 R9");

        // R1: reset in mid-run returns everything to mid-code
        rst_n = 1'b0;
        tick("R1");
        rst_n = 1'b1;

        // R2/R3/R10: random decisions and error signs give each tap a different history
        for (int i = 0; i < 1500; i++) begin
            err_sgn_i = 1'($urandom);
            dec_i     = 1'($urandom);
            tick("R2 R3 R10");
        end

        // R8: adaptation off; counters hold while decisions keep shifting
        adapt_en = 1'b0;
        for (int i = 0; i < 60; i++) begin
            err_sgn_i = 1'($urandom);
            dec_i     = 1'($urandom);
            tick("R8");
        end

        // R2/R8: re-enable; taps must use the decisions shifted in while disabled
        adapt_en = 1'b1;
        for (int i = 0; i < 300; i++) begin
            err_sgn_i = 1'($urandom);
            dec_i     = 1'($urandom);
            tick("R2 R8");
        end

        // R2: alternating decisions with a fixed error sign separate odd and even taps
        err_sgn_i = 1'b1;
        for (int i = 0; i < 200; i++) begin
            dec_i = 1'(i % 2);
            tick("R2");
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule